// File: doc/BRIEF.md
# Single-Cycle Register Datapath Processor

This block is a compact processor core that completes one instruction per clock. A 32-bit instruction word arrives on its instruction input and is captured into an instruction register on a rising edge. During the next cycle the opcode goes through a control lookup that raises the enables for one execution unit. The operands are read from a 32 x 32 register file, and the result is written back at the end of that cycle. The core has three execution units: an adder/subtractor, a bitwise logic unit driven by a 4-bit truth table, and a shifter with three modes. An immediate field replaces the second operand after sign extension.

Loads and stores use a single word-wide memory port. The byte address is the first source register plus the sign-extended offset. Read data is expected back in the same cycle, and a write commits on the clock edge that ends the store cycle. The environment supplies the instruction stream and the memory. The core has no branches or jumps, so the program order is exactly the order in which words are presented.

Top module: `sdp_core`

## Requirements
- R1: Instruction fields are opcode [31:26], destination Z [25:21], source X [20:16], source Y [15:11] and immediate [15:0]. A word present at a rising edge executes in the following cycle. Its register result is written on the edge that ends that cycle. Exactly one unit sources the result in any cycle.
- R2: While reset is low the instruction register holds opcode 000000 (nop). After release, neither memory strobe rises until a memory instruction has been captured.
- R3: Opcode 100000 writes X+Y to Z and opcode 100010 writes X-Y to Z. An instruction can use a result written by the instruction just before it.
- R4: Opcodes 100100, 100101 and 100110 write X AND Y, X OR Y and X XOR Y to Z.
- R5: The immediate forms addi 001000, subi 001001, andi 001100, ori 001101 and xori 001110 use the 16-bit immediate, sign-extended to 32 bits, as the Y operand.
- R6: Left logical shift (register form 101000, immediate form 011000) shifts X by the low 5 bits of the amount and fills with zeros. An amount of 36 acts as 4.
- R7: Right arithmetic shift (101001, immediate 011001) fills from the sign bit of X.
- R8: Right rotate (101010, immediate 011010) moves the bits shifted out of bit 0 into bit 31. An amount of 0 returns X unchanged.
- R9: Load word (100011) raises the read strobe, drives address X + sign-extended offset, and writes the returned word to Z.
- R10: Store word (101011) raises the write strobe for one cycle, drives address X + sign-extended offset and drives the data of register Z. It writes no register.
- R11: Register 0 always reads as zero, and a write addressed to it has no effect.
- R12: Any opcode not listed above behaves as nop: no register write and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction word captured each rising edge |
| mem_addr_o | output | 32 | Byte address for load or store |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Store strobe, commits on the rising edge |
| mem_re_o | output | 1 | Load strobe |
| mem_rdata_i | input | 32 | Combinational read data |

## Verification
The bench uses the default widths: 32-bit data, 32 registers and a 16-bit immediate. With these values, shift amounts up to 31 and the sign bit at position 31 can be exercised. The immediates tested cross the 16-bit sign boundary, and an amount of 36 checks that the upper amount bits are dropped. Every register value is observed through store instructions. A scoreboard compares each store's address and data with values computed by hand, and any store the program did not request counts as a failure.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OP_NOP  = 6'b000000;
  localparam logic [OPC_W-1:0] OP_ADD  = 6'b100000;
  localparam logic [OPC_W-1:0] OP_SUB  = 6'b100010;
  localparam logic [OPC_W-1:0] OP_AND  = 6'b100100;
  localparam logic [OPC_W-1:0] OP_OR   = 6'b100101;
  localparam logic [OPC_W-1:0] OP_XOR  = 6'b100110;
  localparam logic [OPC_W-1:0] OP_SHL  = 6'b101000;
  localparam logic [OPC_W-1:0] OP_SRA  = 6'b101001;
  localparam logic [OPC_W-1:0] OP_ROR  = 6'b101010;
  localparam logic [OPC_W-1:0] OP_ADDI = 6'b001000;
  localparam logic [OPC_W-1:0] OP_SUBI = 6'b001001;
  localparam logic [OPC_W-1:0] OP_ANDI = 6'b001100;
  localparam logic [OPC_W-1:0] OP_ORI  = 6'b001101;
  localparam logic [OPC_W-1:0] OP_XORI = 6'b001110;
  localparam logic [OPC_W-1:0] OP_SHLI = 6'b011000;
  localparam logic [OPC_W-1:0] OP_SRAI = 6'b011001;
  localparam logic [OPC_W-1:0] OP_RORI = 6'b011010;
  localparam logic [OPC_W-1:0] OP_LW   = 6'b100011;
  localparam logic [OPC_W-1:0] OP_SW   = 6'b101011;

  // Truth tables indexed by {x,y}
  localparam logic [3:0] LFN_AND = 4'b1000;
  localparam logic [3:0] LFN_OR  = 4'b1110;
  localparam logic [3:0] LFN_XOR = 4'b0110;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_ARITH = 2'b01,
    SH_ROT   = 2'b10
  } shift_kind_e;

  typedef struct packed {
    logic        reg_we;
    logic        use_imm;
    logic        add_en;
    logic        add_neg;
    logic        bool_en;
    logic [3:0]  bool_tt;
    logic        shf_en;
    shift_kind_e shf_kind;
    logic        store;
    logic        load;
    logic        mem_wr;
    logic        mem_sel;
  } ctl_word_t;

  function automatic logic op_is_known(input logic [OPC_W-1:0] op);
    case (op)
      OP_NOP, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SRA, OP_ROR,
      OP_ADDI, OP_SUBI, OP_ANDI, OP_ORI, OP_XORI, OP_SHLI, OP_SRAI, OP_RORI,
      OP_LW, OP_SW: return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sdp_ctrl_rom.sv
module sdp_ctrl_rom
  import sdp_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output ctl_word_t        ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (opcode_i)
      OP_ADD, OP_ADDI, OP_SUB, OP_SUBI: begin
        ctl_o.reg_we  = 1'b1;
        ctl_o.add_en  = 1'b1;
        ctl_o.add_neg = (opcode_i == OP_SUB) || (opcode_i == OP_SUBI);
        ctl_o.use_imm = (opcode_i == OP_ADDI) || (opcode_i == OP_SUBI);
      end
      OP_AND, OP_ANDI, OP_OR, OP_ORI, OP_XOR, OP_XORI: begin
        ctl_o.reg_we  = 1'b1;
        ctl_o.bool_en = 1'b1;
        ctl_o.use_imm = opcode_i[5] == 1'b0;
        ctl_o.bool_tt = (opcode_i[1:0] == 2'b00) ? LFN_AND :
                        (opcode_i[1:0] == 2'b01) ? LFN_OR : LFN_XOR;
      end
      OP_SHL, OP_SHLI, OP_SRA, OP_SRAI, OP_ROR, OP_RORI: begin
        ctl_o.reg_we   = 1'b1;
        ctl_o.shf_en   = 1'b1;
        ctl_o.use_imm  = opcode_i[5] == 1'b0;
        ctl_o.shf_kind = shift_kind_e'(opcode_i[1:0]);
      end
      OP_LW: begin
        ctl_o.reg_we  = 1'b1;
        ctl_o.use_imm = 1'b1;
        ctl_o.add_en  = 1'b1;
        ctl_o.load    = 1'b1;
        ctl_o.mem_sel = 1'b1;
      end
      OP_SW: begin
        ctl_o.use_imm = 1'b1;
        ctl_o.add_en  = 1'b1;
        ctl_o.store   = 1'b1;
        ctl_o.mem_wr  = 1'b1;
        ctl_o.mem_sel = 1'b1;
      end
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/sdp_regfile.sv
module sdp_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   xa_i,
  input  logic [RA_W-1:0]   ya_i,
  input  logic [RA_W-1:0]   za_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] zd_i,
  output logic [DATA_W-1:0] xd_o,
  output logic [DATA_W-1:0] yd_o
);
  logic [DATA_W-1:0] regs [NREG];
  logic              wr_live;

  assign wr_live = we_i && (za_i != '0);

  always_ff @(posedge clk) begin
    if (wr_live) regs[za_i] <= zd_i;
  end

  assign xd_o = (xa_i == '0) ? '0 : regs[xa_i];
  assign yd_o = (ya_i == '0) ? '0 : regs[ya_i];

  // R3: a write lands in the addressed entry at the closing edge
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_live |=> regs[$past(za_i)] == $past(zd_i));
endmodule

// File: rtl/sdp_exec.sv
module sdp_exec
  import sdp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_imm_i,
  input  logic              add_en_i,
  input  logic              add_neg_i,
  input  logic              bool_en_i,
  input  logic [3:0]        bool_tt_i,
  input  logic              shf_en_i,
  input  shift_kind_e       shf_kind_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] yreg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] mem_rd_i,
  output logic [DATA_W-1:0] z_o,
  output logic [DATA_W-1:0] sum_o
);
  function automatic logic [DATA_W-1:0] f_sext(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] f_bool(input logic [3:0] tt,
                                               input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = tt[{a[i], b[i]}];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] f_shift(input shift_kind_e k,
                                                input logic [DATA_W-1:0] a,
                                                input logic [SH_W-1:0] n);
    case (k)
      SH_LEFT:  return a << n;
      SH_ARITH: return $signed(a) >>> n;
      SH_ROT:   return (a >> n) | (a << (DATA_W - int'(n)));
      default:  return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] y_op, bool_res, shf_res;
  logic [SH_W-1:0]   amt;
  logic              drv_mem, drv_add, drv_bool, drv_shf;

  assign y_op     = use_imm_i ? f_sext(imm_i) : yreg_i;
  assign amt      = y_op[SH_W-1:0];
  assign sum_o    = add_neg_i ? (x_i - y_op) : (x_i + y_op);
  assign bool_res = f_bool(bool_tt_i, x_i, y_op);
  assign shf_res  = f_shift(shf_kind_i, x_i, amt);

  assign drv_mem  = load_i;
  assign drv_add  = add_en_i && !load_i;
  assign drv_bool = bool_en_i;
  assign drv_shf  = shf_en_i;

  always_comb begin
    z_o = '0;
    if (drv_mem)       z_o = mem_rd_i;
    else if (drv_add)  z_o = sum_o;
    else if (drv_bool) z_o = bool_res;
    else if (drv_shf)  z_o = shf_res;
  end

  // R1: at most one unit sources the result bus
  p_one_z_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_mem, drv_add, drv_bool, drv_shf}));

  // R8: any shift or rotate by zero returns X
  p_zero_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_en_i && amt == '0) |-> z_o == x_i);
endmodule

// File: rtl/sdp_core.sv
module sdp_core
  import sdp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NREG    = 32,
  parameter int IMM_W   = 16,
  parameter int INSTR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int RA_W  = $clog2(NREG);
  localparam int OPC_L = INSTR_W - OPC_W;
  localparam int ZA_L  = OPC_L - RA_W;
  localparam int XA_L  = ZA_L - RA_W;
  localparam int YA_L  = XA_L - RA_W;

  logic [INSTR_W-1:0] ir;
  logic [OPC_W-1:0]   opc;
  logic [RA_W-1:0]    za, xa, ya, ya_sel;
  ctl_word_t          ctl;
  logic [DATA_W-1:0]  xd, yd, zbus, sum;
  logic               rf_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir <= '0;
    else        ir <= instr_i;
  end

  assign opc    = ir[INSTR_W-1:OPC_L];
  assign za     = ir[OPC_L-1:ZA_L];
  assign xa     = ir[ZA_L-1:XA_L];
  assign ya     = ir[XA_L-1:YA_L];
  assign ya_sel = ctl.store ? za : ya;
  assign rf_we  = ctl.reg_we;

  sdp_ctrl_rom u_rom (
    .opcode_i (opc),
    .ctl_o    (ctl)
  );

  sdp_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .xa_i  (xa),
    .ya_i  (ya_sel),
    .za_i  (za),
    .we_i  (rf_we),
    .zd_i  (zbus),
    .xd_o  (xd),
    .yd_o  (yd)
  );

  sdp_exec #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ex (
    .clk        (clk),
    .rst_n      (rst_n),
    .use_imm_i  (ctl.use_imm),
    .add_en_i   (ctl.add_en),
    .add_neg_i  (ctl.add_neg),
    .bool_en_i  (ctl.bool_en),
    .bool_tt_i  (ctl.bool_tt),
    .shf_en_i   (ctl.shf_en),
    .shf_kind_i (ctl.shf_kind),
    .load_i     (ctl.load),
    .x_i        (xd),
    .yreg_i     (yd),
    .imm_i      (ir[IMM_W-1:0]),
    .mem_rd_i   (mem_rdata_i),
    .z_o        (zbus),
    .sum_o      (sum)
  );

  assign mem_addr_o  = sum;
  assign mem_wdata_o = yd;
  assign mem_we_o    = ctl.mem_sel && ctl.mem_wr;
  assign mem_re_o    = ctl.mem_sel && !ctl.mem_wr;

  // R2: the first cycle after reset release executes a nop
  p_reset_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (ir == '0 && !mem_we_o && !mem_re_o));

  // R10: a store never writes the register file
  p_store_no_regwrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !rf_we);

  // R9: a load reads memory and writes a register
  p_load_writes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |-> (rf_we && !mem_we_o));

  // R12: unknown opcodes stay silent
  p_undef_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_is_known(opc) |-> (!rf_we && !mem_we_o && !mem_re_o));
endmodule

// File: tb/tb_sdp_core.sv
module tb_sdp_core;
  localparam int CLK_P = 10;

  localparam logic [5:0] C_ADD = 6'b100000, C_SUB = 6'b100010, C_AND = 6'b100100,
    C_OR = 6'b100101, C_XOR = 6'b100110, C_SHL = 6'b101000, C_SRA = 6'b101001,
    C_ROR = 6'b101010, C_ADDI = 6'b001000, C_SUBI = 6'b001001, C_ANDI = 6'b001100,
    C_ORI = 6'b001101, C_XORI = 6'b001110, C_SHLI = 6'b011000, C_SRAI = 6'b011001,
    C_RORI = 6'b011010, C_LW = 6'b100011, C_SW = 6'b101011, C_NOP = 6'b000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_we_o, mem_re_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] slot = 32'h100;

  typedef struct { logic [31:0] a; logic [31:0] d; int req; } exp_t;
  exp_t exp_q[$];

  logic [31:0] ram [256];

  always #(CLK_P/2) clk = ~clk;

  sdp_core dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_i     (instr_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_rdata_i (mem_rdata_i)
  );

  assign mem_rdata_i = ram[mem_addr_o[9:2]];
  always @(posedge clk) if (rst_n && mem_we_o) ram[mem_addr_o[9:2]] <= mem_wdata_o;

  function automatic logic [31:0] rw(logic [5:0] op, int z, int x, int y);
    return {op, 5'(z), 5'(x), 5'(y), 11'b0};
  endfunction
  function automatic logic [31:0] iw(logic [5:0] op, int z, int x, logic [15:0] imm);
    return {op, 5'(z), 5'(x), imm};
  endfunction

  task automatic note(bit ok, int req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w);
    @(negedge clk);
    instr_i = w;
  endtask

  // store register r to the next slot and expect value v
  task automatic put(int r, logic [31:0] v, int req);
    exp_t e;
    e.a = slot; e.d = v; e.req = req;
    exp_q.push_back(e);
    issue(iw(C_SW, r, 0, slot[15:0]));
    slot += 4;
  endtask

  task automatic load_probe(logic [31:0] w, logic [31:0] addr);
    issue(w);
    @(negedge clk);
    note(mem_re_o === 1'b1, 9, "load strobe", {31'b0, mem_re_o}, 32'h1);
    note(mem_addr_o === addr, 9, "load address", mem_addr_o, addr);
    instr_i = '0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: scoreboard compare of every store
  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      if (exp_q.size() == 0) begin
        note(1'b0, 12, "unexpected store addr", mem_addr_o, 32'hx);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        note(mem_addr_o === e.a, e.req, "store address", mem_addr_o, e.a);
        note(mem_wdata_o === e.d, e.req, "store data", mem_wdata_o, e.d);
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    checks++; errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = '0;
    ram[16] = 32'h80000F01;
    ram[17] = 32'h13579BDF;
    repeat (3) @(negedge clk);
    // R2: strobes quiet in reset
    note(mem_we_o === 1'b0 && mem_re_o === 1'b0, 2, "strobes in reset",
         {30'b0, mem_we_o, mem_re_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: first cycle after release is a nop
    note(mem_we_o === 1'b0 && mem_re_o === 1'b0, 2, "strobes after release",
         {30'b0, mem_we_o, mem_re_o}, 32'h0);

    issue(iw(C_ADDI, 1, 0, 16'd100));
    issue(iw(C_ADDI, 2, 0, 16'hFFF9));
    issue(iw(C_ADDI, 3, 0, 16'h0F0F));
    issue(iw(C_ADDI, 5, 0, 16'd4));
    issue(iw(C_ADDI, 19, 0, 16'd36));
    load_probe(iw(C_LW, 4, 0, 16'h0040), 32'h40);   // R9
    load_probe(iw(C_LW, 6, 1, 16'hFFE0), 32'h44);   // R9 negative offset
    put(4, 32'h80000F01, 9);  // R9
    put(6, 32'h13579BDF, 9);  // R9
    put(1, 32'd100, 5);       // R5
    put(2, 32'hFFFFFFF9, 5);  // R5 sign extension

    issue(rw(C_ADD, 7, 1, 2));
    issue(rw(C_SUB, 8, 1, 2));
    issue(rw(C_SUB, 9, 2, 1));
    put(7, 32'd93, 3);        // R3
    put(8, 32'd107, 3);       // R3
    put(9, 32'hFFFFFF95, 3);  // R3
    issue(rw(C_ADD, 30, 1, 1));
    issue(rw(C_SUB, 31, 30, 1));
    put(31, 32'd100, 3);      // R3 back-to-back dependency

    issue(rw(C_AND, 10, 4, 3));
    issue(rw(C_OR, 28, 4, 3));
    issue(rw(C_XOR, 29, 4, 3));
    put(10, 32'h00000F01, 4); // R4
    put(28, 32'h80000F0F, 4); // R4
    put(29, 32'h8000000E, 4); // R4

    issue(iw(C_ADDI, 11, 1, 16'hFFFF));
    issue(iw(C_SUBI, 12, 1, 16'd200));
    issue(iw(C_ANDI, 13, 4, 16'hFF00));
    issue(iw(C_ORI, 14, 1, 16'h8000));
    issue(iw(C_XORI, 15, 3, 16'h00FF));
    put(11, 32'd99, 5);       // R5
    put(12, 32'hFFFFFF9C, 5); // R5
    put(13, 32'h80000F00, 5); // R5
    put(14, 32'hFFFF8064, 5); // R5
    put(15, 32'h00000FF0, 5); // R5

    issue(rw(C_SHL, 16, 4, 5));
    issue(rw(C_SHL, 20, 4, 19));
    issue(iw(C_SHLI, 21, 3, 16'd31));
    put(16, 32'h0000F010, 6); // R6
    put(20, 32'h0000F010, 6); // R6 amount 36 acts as 4
    put(21, 32'h80000000, 6); // R6

    issue(rw(C_SRA, 17, 4, 5));
    issue(iw(C_SRAI, 22, 4, 16'd31));
    issue(iw(C_SRAI, 25, 3, 16'd4));
    put(17, 32'hF80000F0, 7); // R7
    put(22, 32'hFFFFFFFF, 7); // R7
    put(25, 32'h000000F0, 7); // R7

    issue(rw(C_ROR, 18, 4, 5));
    issue(iw(C_RORI, 23, 4, 16'd0));
    issue(iw(C_RORI, 24, 4, 16'd1));
    put(18, 32'h180000F0, 8); // R8
    put(23, 32'h80000F01, 8); // R8
    put(24, 32'hC0000780, 8); // R8

    issue(iw(C_ADDI, 0, 1, 16'd5));
    put(0, 32'h0, 11);        // R11
    issue(rw(C_ADD, 26, 0, 1));
    put(26, 32'd100, 11);     // R11

    issue({6'b111111, 5'd7, 5'd1, 5'd2, 11'b0});
    issue({6'b100001, 5'd7, 5'd1, 5'd2, 11'b0});
    issue({C_NOP, 5'd7, 5'd1, 5'd2, 11'b0});
    put(7, 32'd93, 12);       // R12 destination untouched

    begin
      exp_t e;
      e.a = 32'd96; e.d = 32'd93; e.req = 10;  // R10 store with negative offset
      exp_q.push_back(e);
      issue(iw(C_SW, 7, 1, 16'hFFFC));
    end
    issue(iw(C_LW, 27, 1, 16'hFFFC));
    put(27, 32'd93, 10);      // R10 memory holds stored word

    issue('0);
    repeat (4) @(negedge clk);
    // R1: every issued store appeared
    note(exp_q.size() == 0, 1, "pending stores", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule